// File: doc/BRIEF.md
# JTAG Target Entry and Reset Sequencer

This block takes a debug target from an unknown state to a halted, reset, watchdog-quiet state under JTAG control. After one `start` pulse it drives the target's reset and test-mode pins through a timed pin sequence that selects JTAG debug access. It then probes the security fuse, waits for the target to report that it is synchronised, resets the target through a series of control words and TCLK bursts, and switches off the target's watchdog with one memory write. It ends by checking the control-signal capture, putting the TAP through a reset and pulsing `done`.

The sequencer does no serial shifting itself. Every instruction or data shift, and the final TAP reset, goes out as one request to a JTAG shift engine that other blocks also use. The request is held until the engine returns an acknowledge with the captured data. The pin-level delays come from a clock-cycle timer: `UNIT_CYCLES` clock cycles make one delay unit, and `MS_UNITS` units make one millisecond.

States: `S_IDLE`, `S_RST_LO`, `S_TEST_LO`, `S_TEST_HI`, `S_FUSE_IR`, `S_FUSE_DR`, `S_SYNC_IR`, `S_SYNC_CTL`, `S_SYNC_POLL`, `S_SCRIPT`, `S_BURST`, `S_TAP_RST`, `S_DONE`.

Transitions:
- `S_IDLE` goes to `S_RST_LO` on `start`.
- Each timed state goes to the next one when its timer expires: `S_RST_LO` to `S_TEST_LO`, `S_TEST_LO` to `S_TEST_HI`, and `S_TEST_HI` to `S_FUSE_IR`.
- `S_FUSE_IR` goes to `S_FUSE_DR` on acknowledge.
- `S_FUSE_DR` goes to `S_SYNC_IR` when the echo matches or when the third try is used up. Otherwise it goes back to `S_FUSE_IR`.
- `S_SYNC_IR` goes to `S_SYNC_CTL`, and `S_SYNC_CTL` goes to `S_SYNC_POLL`.
- `S_SYNC_POLL` goes to `S_SCRIPT` when the ready bit is seen. It goes to `S_TAP_RST` on timeout.
- `S_SCRIPT` steps through its operation list. It enters `S_BURST` for the TCLK burst and returns to `S_SCRIPT` afterwards. After the final capture it goes to `S_TAP_RST`.
- `S_TAP_RST` goes to `S_DONE` on acknowledge.
- `S_DONE` goes to `S_IDLE` after one cycle.

Top module: `jtag_entry_seq`

## Requirements
- R1: After `start`, with U = `UNIT_CYCLES`, the pins go through three phases:
  - `pin_rst_oe`=1, `pin_rst_o`=0 and `pin_test_o`=1 for 20·U cycles;
  - then `pin_test_o`=0 for 10·U cycles;
  - then `pin_test_o`=1 for 10·`MS_UNITS`·U cycles.
  After the third phase, `pin_rst_o`=1 and `pin_rst_oe`=0. While the reset pin is driven, no shift is requested, and the reset pin is never driven high.
- R2: The fuse probe runs up to three times. Each try is an instruction shift of 0x14 (8 bits) followed by a 16-bit data shift of 0xAAAA. A returned value of 0x5555 sets `fuse_blown` and ends the probe early. If no try matches, `fuse_blown` stays 0. The sequence continues in both cases.
- R3: The sync step shifts instruction 0x13, then data 0x1501. It then shifts 16-bit zero words until a returned word has bit 9 set.
- R4: If `SYNC_LIMIT` polls return bit 9 clear, the block stops polling, sets `status_err`, skips the reset and watchdog steps, and goes straight to the TAP reset.
- R5: The reset step runs in this order:
  - one TCLK rise;
  - instruction 0x13;
  - data 0x0C01, then 0x0401;
  - exactly ten TCLK rises;
  - data 0x0501;
  - one TCLK rise before the next shift.
- R6: The watchdog write runs in this order:
  - instruction 0x14, then data 0;
  - TCLK low;
  - instruction 0x13, then data 0x0500;
  - instruction 0x83, then a 20-bit data shift of 0x015C;
  - instruction 0x85;
  - TCLK rise;
  - data 0x5A80;
  - TCLK low;
  - instruction 0x13, then data 0x0501;
  - TCLK rise.
- R7: The final check shifts instruction 0x14, then data 0. If the returned value AND 0x0301 is nonzero, `status_ok` is set. Otherwise `status_err` is set. The two are never set together.
- R8: The last request of every sequence is a TAP reset (`sh_kind`=2, `sh_len`=0). `done` is high for exactly one cycle, in the cycle after that request is acknowledged. `status_ok`, `status_err` and `fuse_blown` then hold until the next `start`.
- R9: Request encoding and handshake:
  - `sh_kind` is 0 for an instruction shift, 1 for a data shift and 2 for a TAP reset.
  - `sh_len` is 8 for instruction shifts and 16 or 20 for data shifts.
  - The shift value sits right-aligned in `sh_out`.
  - A request holds its kind, length and value stable until `sh_ack`, and each acknowledge completes exactly one request.
- R10: `start` has no effect while a sequence is running.
- R11: After reset, all of the following are low: `sh_req`, `done`, `status_ok`, `status_err`, `fuse_blown`, `pin_rst_oe`, `pin_test_o` and `pin_tclk_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the entry sequence (used only when idle) |
| pin_rst_o | output | 1 | Target reset pin level |
| pin_rst_oe | output | 1 | Target reset pin output enable |
| pin_test_o | output | 1 | Target test-mode pin level |
| pin_tclk_o | output | 1 | Target TCLK level |
| sh_req | output | 1 | Shift request to the JTAG engine |
| sh_kind | output | 2 | 0 instruction, 1 data, 2 TAP reset |
| sh_len | output | 5 | Number of bits to shift |
| sh_out | output | 20 | Value to shift in, right-aligned |
| sh_ack | input | 1 | Engine finished the request, `sh_in` valid |
| sh_in | input | 20 | Value captured by the shift |
| fuse_blown | output | 1 | Fuse echo pattern was seen |
| status_ok | output | 1 | Final control-signal check passed |
| status_err | output | 1 | Final check failed or sync timed out |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench acts as the shift engine and logs every request together with the number of TCLK rises seen so far. This exposes a burst of the wrong length, or a TCLK edge on the wrong side of a shift, as a wrong snapshot at the 0x0501 word or the 0x5A80 word.

The fuse probe is driven to match on the second and on the third try, and also never to match. A design that kept probing after a match, or that stopped after two tries, produces a different request count.

A target that never raises the ready bit checks that the poll gives up after exactly the limit and skips straight to the TAP reset. A final capture whose set bits all lie outside 0x0301 checks that the error path is taken.

A second `start` pulse in the middle of a run would restart the timed pin phases if it were accepted. The bench catches this through the phase cycle counts, the request log and the `done` count.

// File: rtl/jseq_pkg.sv
package jseq_pkg;

    localparam int DW = 20;

    typedef enum logic [1:0] {
        SK_IR     = 2'd0,
        SK_DR     = 2'd1,
        SK_TAPRST = 2'd2
    } shkind_e;

    typedef enum logic [2:0] {
        OP_TLO,
        OP_THI,
        OP_IR,
        OP_DR16,
        OP_DR20,
        OP_BURST,
        OP_CHECK
    } op_e;

    typedef struct packed {
        op_e           op;
        logic [DW-1:0] val;
    } step_t;

    localparam logic [7:0] IRC_CAPTURE   = 8'h14;
    localparam logic [7:0] IRC_CTRL16    = 8'h13;
    localparam logic [7:0] IRC_ADDR16    = 8'h83;
    localparam logic [7:0] IRC_DATA2ADDR = 8'h85;

    localparam logic [15:0] FUSE_PROBE = 16'hAAAA;
    localparam logic [15:0] FUSE_ECHO  = 16'h5555;
    localparam logic [15:0] SYNC_WORD  = 16'h1501;
    localparam int          READY_BIT  = 9;
    localparam logic [15:0] OK_MASK    = 16'h0301;
    localparam int          BURST_LEN  = 10;
    localparam int          FUSE_TRIES = 3;

endpackage

// File: rtl/jseq_timer.sv
module jseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/jseq_script.sv
module jseq_script
    import jseq_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);
    function automatic step_t mk(op_e o, logic [DW-1:0] v);
        step_t s;
        s.op  = o;
        s.val = v;
        return s;
    endfunction

    always_comb begin
        unique case (idx)
            // target reset through control words
            5'd0:    step = mk(OP_TLO,   '0);
            5'd1:    step = mk(OP_THI,   '0);
            5'd2:    step = mk(OP_IR,    DW'(IRC_CTRL16));
            5'd3:    step = mk(OP_DR16,  20'h00C01);
            5'd4:    step = mk(OP_DR16,  20'h00401);
            5'd5:    step = mk(OP_BURST, '0);
            5'd6:    step = mk(OP_DR16,  20'h00501);
            5'd7:    step = mk(OP_TLO,   '0);
            5'd8:    step = mk(OP_THI,   '0);
            // watchdog-disable memory write
            5'd9:    step = mk(OP_IR,    DW'(IRC_CAPTURE));
            5'd10:   step = mk(OP_DR16,  '0);
            5'd11:   step = mk(OP_TLO,   '0);
            5'd12:   step = mk(OP_IR,    DW'(IRC_CTRL16));
            5'd13:   step = mk(OP_DR16,  20'h00500);
            5'd14:   step = mk(OP_IR,    DW'(IRC_ADDR16));
            5'd15:   step = mk(OP_DR20,  20'h0015C);
            5'd16:   step = mk(OP_IR,    DW'(IRC_DATA2ADDR));
            5'd17:   step = mk(OP_THI,   '0);
            5'd18:   step = mk(OP_DR16,  20'h05A80);
            5'd19:   step = mk(OP_TLO,   '0);
            5'd20:   step = mk(OP_IR,    DW'(IRC_CTRL16));
            5'd21:   step = mk(OP_DR16,  20'h00501);
            5'd22:   step = mk(OP_THI,   '0);
            // final control-signal check
            5'd23:   step = mk(OP_IR,    DW'(IRC_CAPTURE));
            default: step = mk(OP_CHECK, '0);
        endcase
    end
endmodule

// File: rtl/jtag_entry_seq.sv
module jtag_entry_seq
    import jseq_pkg::*;
#(
    parameter int UNIT_CYCLES = 50,
    parameter int MS_UNITS    = 1000,
    parameter int SYNC_LIMIT  = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          pin_rst_o,
    output logic          pin_rst_oe,
    output logic          pin_test_o,
    output logic          pin_tclk_o,
    output logic          sh_req,
    output logic [1:0]    sh_kind,
    output logic [4:0]    sh_len,
    output logic [19:0]   sh_out,
    input  logic          sh_ack,
    input  logic [19:0]   sh_in,
    output logic          fuse_blown,
    output logic          status_ok,
    output logic          status_err,
    output logic          done
);
    localparam int D_RST  = 20 * UNIT_CYCLES;
    localparam int D_TLO  = 10 * UNIT_CYCLES;
    localparam int D_THI  = 10 * MS_UNITS * UNIT_CYCLES;
    localparam int TW     = $clog2(D_THI + 1);
    localparam int PW     = $clog2(SYNC_LIMIT + 1);
    localparam int BW     = $clog2(2 * BURST_LEN);
    localparam int IDX_W  = 5;

    typedef enum logic [3:0] {
        S_IDLE, S_RST_LO, S_TEST_LO, S_TEST_HI,
        S_FUSE_IR, S_FUSE_DR, S_SYNC_IR, S_SYNC_CTL, S_SYNC_POLL,
        S_SCRIPT, S_BURST, S_TAP_RST, S_DONE
    } state_e;

    state_e           state_q;
    logic [IDX_W-1:0] idx_q;
    logic [BW-1:0]    bcnt_q;
    logic [1:0]       try_q;
    logic [PW-1:0]    poll_q;
    logic             tclk_q, fuse_q, ok_q, err_q, entered_q;

    logic             tmr_load, tmr_zero;
    logic [TW-1:0]    tmr_val;
    step_t            step;
    logic             step_shift;

    jseq_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .zero  (tmr_zero)
    );

    jseq_script #(.IDX_W(IDX_W)) u_script (
        .idx  (idx_q),
        .step (step)
    );

    assign step_shift = (step.op == OP_IR) || (step.op == OP_DR16) ||
                        (step.op == OP_DR20) || (step.op == OP_CHECK);

    // state register and sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            idx_q     <= '0;
            bcnt_q    <= '0;
            try_q     <= '0;
            poll_q    <= '0;
            tclk_q    <= 1'b0;
            fuse_q    <= 1'b0;
            ok_q      <= 1'b0;
            err_q     <= 1'b0;
            entered_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    state_q <= S_RST_LO;
                    fuse_q  <= 1'b0;
                    ok_q    <= 1'b0;
                    err_q   <= 1'b0;
                    tclk_q  <= 1'b0;
                    try_q   <= '0;
                    poll_q  <= '0;
                    idx_q   <= '0;
                end
                S_RST_LO:  if (tmr_zero) state_q <= S_TEST_LO;
                S_TEST_LO: if (tmr_zero) begin
                    state_q   <= S_TEST_HI;
                    entered_q <= 1'b1;
                end
                S_TEST_HI: if (tmr_zero) state_q <= S_FUSE_IR;
                S_FUSE_IR: if (sh_ack) state_q <= S_FUSE_DR;
                S_FUSE_DR: if (sh_ack) begin
                    if (sh_in[15:0] == FUSE_ECHO) begin
                        fuse_q  <= 1'b1;
                        state_q <= S_SYNC_IR;
                    end else if (try_q == 2'(FUSE_TRIES - 1)) begin
                        state_q <= S_SYNC_IR;
                    end else begin
                        try_q   <= try_q + 1'b1;
                        state_q <= S_FUSE_IR;
                    end
                end
                S_SYNC_IR:  if (sh_ack) state_q <= S_SYNC_CTL;
                S_SYNC_CTL: if (sh_ack) state_q <= S_SYNC_POLL;
                S_SYNC_POLL: if (sh_ack) begin
                    if (sh_in[READY_BIT]) begin
                        state_q <= S_SCRIPT;
                    end else if (poll_q == PW'(SYNC_LIMIT - 1)) begin
                        err_q   <= 1'b1;
                        state_q <= S_TAP_RST;
                    end else begin
                        poll_q  <= poll_q + 1'b1;
                    end
                end
                S_SCRIPT: begin
                    unique case (step.op)
                        OP_TLO: begin
                            tclk_q <= 1'b0;
                            idx_q  <= idx_q + 1'b1;
                        end
                        OP_THI: begin
                            tclk_q <= 1'b1;
                            idx_q  <= idx_q + 1'b1;
                        end
                        OP_BURST: begin
                            bcnt_q  <= '0;
                            state_q <= S_BURST;
                        end
                        OP_CHECK: if (sh_ack) begin
                            ok_q    <= |(sh_in[15:0] & OK_MASK);
                            err_q   <= ~|(sh_in[15:0] & OK_MASK);
                            state_q <= S_TAP_RST;
                        end
                        default: if (sh_ack) idx_q <= idx_q + 1'b1;
                    endcase
                end
                S_BURST: begin
                    tclk_q <= bcnt_q[0];
                    if (bcnt_q == BW'(2 * BURST_LEN - 1)) begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= S_SCRIPT;
                    end else begin
                        bcnt_q  <= bcnt_q + 1'b1;
                    end
                end
                S_TAP_RST: if (sh_ack) state_q <= S_DONE;
                S_DONE:    state_q <= S_IDLE;
                default:   state_q <= S_IDLE;
            endcase
        end
    end

    // outputs and timer loads
    always_comb begin
        pin_rst_oe = 1'b0;
        pin_rst_o  = 1'b1;
        pin_test_o = entered_q;
        sh_req     = 1'b0;
        sh_kind    = SK_IR;
        sh_len     = 5'd8;
        sh_out     = '0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (state_q)
            S_IDLE: begin
                tmr_load = start;
                tmr_val  = TW'(D_RST - 1);
            end
            S_RST_LO: begin
                pin_rst_oe = 1'b1;
                pin_rst_o  = 1'b0;
                pin_test_o = 1'b1;
                tmr_load   = tmr_zero;
                tmr_val    = TW'(D_TLO - 1);
            end
            S_TEST_LO: begin
                pin_rst_oe = 1'b1;
                pin_rst_o  = 1'b0;
                pin_test_o = 1'b0;
                tmr_load   = tmr_zero;
                tmr_val    = TW'(D_THI - 1);
            end
            S_TEST_HI: begin
                pin_rst_oe = 1'b1;
                pin_rst_o  = 1'b0;
            end
            S_FUSE_IR, S_SYNC_IR: begin
                sh_req = 1'b1;
                sh_out = (state_q == S_FUSE_IR) ? DW'(IRC_CAPTURE) : DW'(IRC_CTRL16);
            end
            S_FUSE_DR, S_SYNC_CTL, S_SYNC_POLL: begin
                sh_req  = 1'b1;
                sh_kind = SK_DR;
                sh_len  = 5'd16;
                sh_out  = (state_q == S_FUSE_DR)  ? DW'(FUSE_PROBE) :
                          (state_q == S_SYNC_CTL) ? DW'(SYNC_WORD) : '0;
            end
            S_SCRIPT: begin
                sh_req  = step_shift;
                sh_kind = (step.op == OP_IR) ? SK_IR : SK_DR;
                sh_len  = (step.op == OP_IR)   ? 5'd8  :
                          (step.op == OP_DR20) ? 5'd20 : 5'd16;
                sh_out  = step.val;
            end
            S_TAP_RST: begin
                sh_req  = 1'b1;
                sh_kind = SK_TAPRST;
                sh_len  = 5'd0;
            end
            default: ;
        endcase
    end

    assign pin_tclk_o = tclk_q;
    assign fuse_blown = fuse_q;
    assign status_ok  = ok_q;
    assign status_err = err_q;
    assign done       = (state_q == S_DONE);
endmodule

// File: rtl/jseq_checker.sv
module jseq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        pin_rst_o,
    input logic        pin_rst_oe,
    input logic        sh_req,
    input logic [1:0]  sh_kind,
    input logic [4:0]  sh_len,
    input logic [19:0] sh_out,
    input logic        sh_ack,
    input logic        status_ok,
    input logic        status_err,
    input logic        done
);
    p_rst_never_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rst_oe |-> !pin_rst_o);

    p_no_shift_in_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rst_oe |-> !sh_req);

    p_status_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_ok && status_err));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_tap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(sh_ack) && ($past(sh_kind) == 2'd2));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_req && !sh_ack) |=> sh_req && $stable(sh_kind) && $stable(sh_len) && $stable(sh_out));
endmodule

bind jtag_entry_seq jseq_checker u_jseq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_rst_o  (pin_rst_o),
    .pin_rst_oe (pin_rst_oe),
    .sh_req     (sh_req),
    .sh_kind    (sh_kind),
    .sh_len     (sh_len),
    .sh_out     (sh_out),
    .sh_ack     (sh_ack),
    .status_ok  (status_ok),
    .status_err (status_err),
    .done       (done)
);

// File: tb/tb_jtag_entry_seq.sv
`timescale 1ns/1ps
module tb_jtag_entry_seq;
    localparam int UC = 2, MSU = 5, SL = 8;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic pin_rst_o, pin_rst_oe, pin_test_o, pin_tclk_o;
    logic sh_req, sh_ack, fuse_blown, status_ok, status_err, done;
    logic [1:0]  sh_kind;
    logic [4:0]  sh_len;
    logic [19:0] sh_out, sh_in;

    always #10 clk = ~clk;

    jtag_entry_seq #(.UNIT_CYCLES(UC), .MS_UNITS(MSU), .SYNC_LIMIT(SL)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pin_rst_o(pin_rst_o), .pin_rst_oe(pin_rst_oe), .pin_test_o(pin_test_o),
        .pin_tclk_o(pin_tclk_o), .sh_req(sh_req), .sh_kind(sh_kind), .sh_len(sh_len),
        .sh_out(sh_out), .sh_ack(sh_ack), .sh_in(sh_in), .fuse_blown(fuse_blown),
        .status_ok(status_ok), .status_err(status_err), .done(done));

    int n_chk = 0, n_bad = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // request log (engine side) and expected list
    int ntx, nexp;
    logic [1:0]  lk[64], ek[64];
    logic [4:0]  ll[64], el[64];
    logic [19:0] ld[64], ed[64];
    int          lr[64];

    // monitor state
    int rises, ph_a, ph_b, ph_c, ndone;
    bit seen_tlo, tclk_prev;

    // responder policy
    logic [15:0] fuse_resp[3];
    logic [15:0] final_resp;
    int fidx, polls, k_polls;
    bit after_sync, after_wd;

    always @(negedge clk) begin
        if (pin_tclk_o && !tclk_prev) rises++;
        tclk_prev = pin_tclk_o;
        if (pin_rst_oe && !pin_rst_o) begin
            if (!pin_test_o) begin ph_b++; seen_tlo = 1; end
            else if (!seen_tlo) ph_a++;
            else ph_c++;
        end
        if (done) ndone++;
    end

    initial begin
        sh_ack = 1'b0;
        sh_in  = '0;
        forever begin
            @(negedge clk);
            #1;
            if (sh_req) begin
                logic [19:0] r;
                r = '0;
                if (ntx < 64) begin
                    lk[ntx] = sh_kind; ll[ntx] = sh_len; ld[ntx] = sh_out; lr[ntx] = rises;
                end
                ntx++;
                if (sh_kind == 2'd1) begin
                    if (sh_out == 20'hAAAA) begin
                        r = {4'h0, fuse_resp[fidx > 2 ? 2 : fidx]};
                        fidx++;
                    end else if (sh_out == 20'h1501) begin
                        after_sync = 1;
                    end else if (sh_out == 20'h0 && after_sync) begin
                        polls++;
                        if (polls > k_polls) begin
                            r = 20'h00200;
                            after_sync = 0;
                        end
                    end else if (sh_out == 20'h5A80) begin
                        after_wd = 1;
                    end else if (sh_out == 20'h0 && after_wd) begin
                        r = {4'h0, final_resp};
                        after_wd = 0;
                    end
                end
                @(negedge clk);
                sh_in  = r;
                sh_ack = 1'b1;
                @(negedge clk);
                sh_ack = 1'b0;
                sh_in  = '0;
            end
        end
    end

    task automatic push(logic [1:0] k, logic [4:0] l, logic [19:0] d);
        ek[nexp] = k; el[nexp] = l; ed[nexp] = d; nexp++;
    endtask

    task automatic build_exp(int fuse_pairs, int npolls, bit script);
        nexp = 0;
        for (int i = 0; i < fuse_pairs; i++) begin
            push(0, 8, 20'h14);
            push(1, 16, 20'hAAAA);
        end
        push(0, 8, 20'h13);
        push(1, 16, 20'h1501);
        for (int i = 0; i < npolls; i++) push(1, 16, 20'h0);
        if (script) begin
            push(0, 8, 20'h13);   push(1, 16, 20'h0C01); push(1, 16, 20'h0401);
            push(1, 16, 20'h0501);
            push(0, 8, 20'h14);   push(1, 16, 20'h0);    push(0, 8, 20'h13);
            push(1, 16, 20'h0500); push(0, 8, 20'h83);   push(1, 20, 20'h015C);
            push(0, 8, 20'h85);   push(1, 16, 20'h5A80); push(0, 8, 20'h13);
            push(1, 16, 20'h0501); push(0, 8, 20'h14);   push(1, 16, 20'h0);
        end
        push(2, 0, 20'h0);
    endtask

    task automatic cmp_range(int lo, int hi, string req);
        int bad = -1;
        for (int i = lo; i < hi; i++)
            if (bad < 0 && (lk[i] !== ek[i] || ll[i] !== el[i] || ld[i] !== ed[i])) bad = i;
        if (bad >= 0)
            check(0, req, $sformatf("request %0d kind/len/data", bad),
                  {lk[bad], ll[bad], ld[bad]}, {ek[bad], el[bad], ed[bad]});
        else
            check(1, req, "requests", 0, 0);
    endtask

    task automatic run_seq(logic [15:0] f0, logic [15:0] f1, logic [15:0] f2,
                           int kp, logic [15:0] fin, bit poke_start);
        ntx = 0; rises = 0; ph_a = 0; ph_b = 0; ph_c = 0; ndone = 0; seen_tlo = 0;
        fuse_resp[0] = f0; fuse_resp[1] = f1; fuse_resp[2] = f2;
        final_resp = fin; k_polls = kp; fidx = 0; polls = 0;
        after_sync = 0; after_wd = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < 3000 && ndone == 0; c++) begin
            @(negedge clk);
            if (poke_start && c == 200) start = 1'b1;
            if (poke_start && c == 201) start = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        check(!sh_req && !done && !status_ok && !status_err && !fuse_blown,
              "R11", "control outputs after reset",
              {sh_req, done, status_ok, status_err, fuse_blown}, 0);
        check(!pin_rst_oe && !pin_test_o && !pin_tclk_o, "R11", "pins after reset",
              {pin_rst_oe, pin_test_o, pin_tclk_o}, 0);
    endtask

    task automatic t_normal;
        run_seq(16'h1234, 16'h0000, 16'hFFFF, 2, 16'h0001, 0);
        check(ph_a == 20*UC, "R1", "rst-low phase cycles", ph_a, 20*UC);
        check(ph_b == 10*UC, "R1", "test-low phase cycles", ph_b, 10*UC);
        check(ph_c == 10*MSU*UC, "R1", "test-high phase cycles", ph_c, 10*MSU*UC);
        check(pin_rst_o && !pin_rst_oe && pin_test_o, "R1", "pins after entry",
              {pin_rst_o, pin_rst_oe, pin_test_o}, 3'b101);
        build_exp(3, 3, 1);
        check(ntx == nexp, "R9", "request count", ntx, nexp);
        cmp_range(0, 6, "R2");
        check(!fuse_blown, "R2", "fuse_blown without echo", fuse_blown, 0);
        cmp_range(6, 11, "R3");
        cmp_range(11, 15, "R5");
        check(lr[12] == 1, "R5", "rises before 0x0C01", lr[12], 1);
        check(lr[14] == 11, "R5", "rises at 0x0501", lr[14], 11);
        check(lr[15] == 12, "R5", "rises at next capture", lr[15], 12);
        cmp_range(15, 25, "R6");
        check(lr[22] == 13, "R6", "rises at 0x5A80", lr[22], 13);
        check(lr[24] == 13, "R6", "rises at write end word", lr[24], 13);
        check(lr[25] == 14, "R6", "rises at final capture", lr[25], 14);
        cmp_range(25, 27, "R7");
        check(status_ok && !status_err, "R7", "ok status", {status_ok, status_err}, 2'b10);
        check(ld[27] == 0 && lk[27] == 2, "R8", "last request is TAP reset", lk[27], 2);
        check(ndone == 1, "R8", "done pulse count", ndone, 1);
    endtask

    task automatic t_fuse_second;
        run_seq(16'h0F0F, 16'h5555, 16'h0000, 0, 16'h0300, 0);
        build_exp(2, 1, 1);
        check(ntx == nexp, "R2", "requests with early fuse match", ntx, nexp);
        cmp_range(0, nexp, "R2");
        check(fuse_blown, "R2", "fuse_blown on second try", fuse_blown, 1);
        check(status_ok && !status_err, "R7", "ok on 0x0300", {status_ok, status_err}, 2'b10);
    endtask

    task automatic t_fuse_third_err;
        run_seq(16'h0000, 16'h0000, 16'h5555, 1, 16'h0CFE, 0);
        build_exp(3, 2, 1);
        check(ntx == nexp, "R2", "requests with third-try match", ntx, nexp);
        check(fuse_blown, "R2", "fuse_blown on third try", fuse_blown, 1);
        check(!status_ok && status_err, "R7", "error on masked-zero capture",
              {status_ok, status_err}, 2'b01);
        check(ndone == 1, "R8", "done pulse count", ndone, 1);
    endtask

    task automatic t_sync_timeout;
        run_seq(16'h0, 16'h0, 16'h0, 1000, 16'h0001, 0);
        build_exp(3, SL, 0);
        check(ntx == nexp, "R4", "requests on sync timeout", ntx, nexp);
        cmp_range(0, nexp, "R4");
        check(!status_ok && status_err, "R4", "error on timeout", {status_ok, status_err}, 2'b01);
        check(rises == 0, "R4", "no TCLK rises on timeout", rises, 0);
        check(ndone == 1, "R8", "done after timeout", ndone, 1);
    endtask

    task automatic t_busy_start;
        run_seq(16'h0, 16'h0, 16'h0, 0, 16'h0100, 1);
        build_exp(3, 1, 1);
        check(ntx == nexp, "R10", "requests with start while busy", ntx, nexp);
        check(ph_a == 20*UC && ph_b == 10*UC, "R10", "entry phases not restarted",
              ph_a + ph_b, 30*UC);
        check(ndone == 1, "R10", "single done", ndone, 1);
        check(status_ok, "R10", "status after ignored start", status_ok, 1);
    endtask

    initial begin
        ntx = 0; nexp = 0; ndone = 0; rises = 0; tclk_prev = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_normal();
        t_fuse_second();
        t_fuse_third_err();
        t_sync_timeout();
        t_busy_start();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #3000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule